// File: doc/BRIEF.md
# Bounded Prefetch Read Master

This block sits on the system-bus side of a bus bridge. It issues the burst reads that fill a prefetch FIFO while a read-multiple transaction is being served to the PCI side. When it receives a start pulse it takes the starting word address and the claimed address window, given as a base and a length in words. It then issues bursts that keep the FIFO as full as the free space allows. It never fetches past the last word of the window.

Every burst length is the smallest of three values: the free space in the FIFO, the words left in the window, and a fixed maximum burst. A burst stops when the slave terminates it, when the granted beats run out, or when the window is used up. The address moves forward one word for each accepted beat, so a burst that the slave cuts short, or a request that is rearbitrated, is issued again from the next unread word. A rearbitrate on the very first request, a slave error, and the end of the window are not retried. Each of these is reported on its own status pulse to the target sequencer. When the target side disconnects, fetching stops and any burst still in flight is abandoned.

Top module: `prefetch_rd_master`

## Requirements
- R1: After reset the block is idle, with busReq, fifoWr, busAbort, retryOut, errOut and winEnd all low. One cycle after a startReq pulse, busReq is high and busAddr equals startAddr, provided the FIFO has space and the window has words left.
- R2: While busReq is high, busLen equals min(fifoFree, window end minus busAddr, 16). Window end is winBase plus winLen.
- R3: Each slave data beat in a burst drives fifoWr high in the same cycle. Once all busLen beats are accepted, the next request starts at the previous busAddr plus busLen.
- R4: No beat is ever written for an address at or beyond the window end. When the address reaches the window end, winEnd pulses for one cycle, busReq stays low, and errOut stays low.
- R5: While fifoFree is 0, busReq stays low. A request is issued as soon as space appears.
- R6: A rearbitrate on the first request of a transaction makes retryOut pulse in that cycle. The block then goes idle with no FIFO writes.
- R7: A rearbitrate on any later request leaves retryOut low. The same address is requested again in the next cycle.
- R8: A slave burst terminate ends the burst. The next cycle requests the word after the last accepted beat, with a newly computed length.
- R9: A slave error during a request or a burst makes errOut pulse in that cycle. The beat that comes with it is not written, and the block is idle from the next cycle.
- R10: When tgtDisc is high, busReq and fifoWr are low in that cycle and in the next one. busAbort is high in that cycle if a burst was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse for a read-multiple prefetch |
| startAddr | input | 32 | First word address to fetch |
| winBase | input | 32 | First word address of the claimed window |
| winLen | input | 32 | Window length in words (at least 1) |
| fifoFree | input | 6 | Free words in the prefetch FIFO |
| tgtDisc | input | 1 | Target side has disconnected |
| slvAddrAck | input | 1 | Slave accepted the current request |
| slvRearb | input | 1 | Slave asks for the request to be rearbitrated |
| slvData | input | 1 | Slave delivers one read beat |
| slvBurstTerm | input | 1 | Slave ends the current burst |
| slvErr | input | 1 | Slave error or address-phase timeout |
| busReq | output | 1 | Burst read request |
| busAddr | output | 32 | Word address of the request or the current beat |
| busLen | output | 5 | Requested burst length in words |
| fifoWr | output | 1 | Write the current beat into the FIFO |
| busAbort | output | 1 | Abandon the outstanding burst |
| retryOut | output | 1 | First request rearbitrated: tell the sequencer to issue a PCI retry |
| errOut | output | 1 | Slave error seen: prefetch stopped |
| winEnd | output | 1 | Window exhausted: prefetch stopped |

## Verification
The assertions assume that the slave acts only on the block's own requests. They assume that address acknowledge, rearbitrate and error are never asserted together, that data beats never go beyond the granted length, and that the FIFO free count never drops during a burst. The stimulus holds to these rules because each response is raised by a directed task, and only in the cycle after the bench has seen busReq or an active burst at the ports. Every start address the bench uses lies inside its window, and each window is non-empty.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } pfmState_e;

  typedef struct packed {
    logic load;
    logic ackLoad;
    logic beat;
  } pfmStrobe_t;
endpackage

// File: rtl/pfm_datapath.sv
module pfm_datapath
  import pfm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FREE_W    = 6,
  parameter int MAX_BURST = 16,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfmStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLen,
  input  logic [FREE_W-1:0] fifoFree,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  burstLen,
  output logic              remZero,
  output logic              freeZero,
  output logic              lastBeat
);
  localparam logic [ADDR_W-1:0] MAX_WIDE = ADDR_W'(MAX_BURST);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] endQ;
  logic [LEN_W-1:0]  beatsQ;
  logic [ADDR_W-1:0] remaining;
  logic [ADDR_W-1:0] freeWide;
  logic [ADDR_W-1:0] capA;
  logic [ADDR_W-1:0] capB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      endQ   <= '0;
      beatsQ <= '0;
    end else if (strb.load) begin
      addrQ  <= startAddr;
      endQ   <= winBase + winLen;
      beatsQ <= '0;
    end else begin
      if (strb.ackLoad) beatsQ <= burstLen;
      if (strb.beat) begin
        addrQ  <= addrQ + ADDR_W'(1);
        beatsQ <= beatsQ - LEN_W'(1);
      end
    end
  end

  always_comb begin
    remaining = endQ - addrQ;
    freeWide  = ADDR_W'(fifoFree);
    capA      = (remaining < MAX_WIDE) ? remaining : MAX_WIDE;
    capB      = (freeWide < capA) ? freeWide : capA;
    burstLen  = capB[LEN_W-1:0];
    remZero   = (remaining == '0);
    freeZero  = (fifoFree == '0);
    lastBeat  = (beatsQ == LEN_W'(1));
    curAddr   = addrQ;
  end

  // R4
  beat_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |-> (addrQ != endQ));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |=> (addrQ == $past(addrQ) + ADDR_W'(1)));

  // R3
  beat_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |-> (beatsQ != '0));
endmodule

// File: rtl/pfm_control.sv
module pfm_control
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       tgtDisc,
  input  logic       slvAddrAck,
  input  logic       slvRearb,
  input  logic       slvData,
  input  logic       slvBurstTerm,
  input  logic       slvErr,
  input  logic       remZero,
  input  logic       freeZero,
  input  logic       lastBeat,
  output pfmStrobe_t strb,
  output logic       busReq,
  output logic       fifoWr,
  output logic       busAbort,
  output logic       retryOut,
  output logic       errOut,
  output logic       winEnd
);
  pfmState_e stQ, stD;
  logic      firstQ, firstD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      firstQ <= 1'b0;
    end else begin
      stQ    <= stD;
      firstQ <= firstD;
    end
  end

  always_comb begin
    stD      = stQ;
    firstD   = firstQ;
    strb     = '0;
    busReq   = (stQ == ST_REQ) && !remZero && !freeZero && !tgtDisc;
    inData   = (stQ == ST_DATA);
    fifoWr   = inData && slvData && !tgtDisc && !slvErr;
    busAbort = inData && tgtDisc;
    errOut   = !tgtDisc && slvErr && (busReq || inData);
    retryOut = busReq && slvRearb && firstQ && !slvErr && !slvAddrAck;
    winEnd   = (stQ == ST_REQ) && remZero && !tgtDisc;
    strb.beat = fifoWr;

    unique case (stQ)
      ST_IDLE: begin
        if (startReq) begin
          stD       = ST_REQ;
          firstD    = 1'b1;
          strb.load = 1'b1;
        end
      end
      ST_REQ: begin
        if (tgtDisc || remZero) begin
          stD = ST_IDLE;
        end else if (busReq) begin
          if (slvErr) begin
            stD = ST_IDLE;
          end else if (slvAddrAck) begin
            stD          = ST_DATA;
            firstD       = 1'b0;
            strb.ackLoad = 1'b1;
          end else if (slvRearb && firstQ) begin
            stD = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (tgtDisc || slvErr) begin
          stD = ST_IDLE;
        end else if ((slvData && lastBeat) || slvBurstTerm) begin
          stD = ST_REQ;
        end
      end
      default: stD = ST_IDLE;
    endcase
  end

  logic inData;

  // R10
  disc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtDisc |=> (!busReq && !fifoWr));

  // R6
  retry_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryOut |=> (!busReq && !fifoWr));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> (!busReq && !fifoWr));

  // R4
  win_end_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |-> (!busReq && !errOut && !fifoWr));

  // R5
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeZero |-> !busReq);

  // R6
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({retryOut, errOut, winEnd}));
endmodule

// File: rtl/prefetch_rd_master.sv
module prefetch_rd_master
  import pfm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FREE_W    = 6,
  parameter int MAX_BURST = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLen,
  input  logic [FREE_W-1:0] fifoFree,
  input  logic              tgtDisc,
  input  logic              slvAddrAck,
  input  logic              slvRearb,
  input  logic              slvData,
  input  logic              slvBurstTerm,
  input  logic              slvErr,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LEN_W-1:0]  busLen,
  output logic              fifoWr,
  output logic              busAbort,
  output logic              retryOut,
  output logic              errOut,
  output logic              winEnd
);
  pfmStrobe_t strb;
  logic       remZero;
  logic       freeZero;
  logic       lastBeat;

  pfm_datapath #(
    .ADDR_W(ADDR_W), .FREE_W(FREE_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .startAddr(startAddr), .winBase(winBase), .winLen(winLen),
    .fifoFree(fifoFree),
    .curAddr(busAddr), .burstLen(busLen),
    .remZero(remZero), .freeZero(freeZero), .lastBeat(lastBeat)
  );

  pfm_control u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tgtDisc(tgtDisc),
    .slvAddrAck(slvAddrAck), .slvRearb(slvRearb), .slvData(slvData),
    .slvBurstTerm(slvBurstTerm), .slvErr(slvErr),
    .remZero(remZero), .freeZero(freeZero), .lastBeat(lastBeat),
    .strb(strb), .busReq(busReq), .fifoWr(fifoWr), .busAbort(busAbort),
    .retryOut(retryOut), .errOut(errOut), .winEnd(winEnd)
  );

  // R2
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busLen != '0) && (busLen <= LEN_W'(MAX_BURST)));
endmodule

// File: tb/prefetch_rd_master_test.sv
module prefetch_rd_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq;
  logic [31:0] startAddr, winBase, winLen;
  logic [5:0]  fifoFree;
  logic        tgtDisc, slvAddrAck, slvRearb, slvData, slvBurstTerm, slvErr;
  logic        busReq, fifoWr, busAbort, retryOut, errOut, winEnd;
  logic [31:0] busAddr;
  logic [4:0]  busLen;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prefetch_rd_master uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .winBase(winBase), .winLen(winLen), .fifoFree(fifoFree),
    .tgtDisc(tgtDisc), .slvAddrAck(slvAddrAck), .slvRearb(slvRearb),
    .slvData(slvData), .slvBurstTerm(slvBurstTerm), .slvErr(slvErr),
    .busReq(busReq), .busAddr(busAddr), .busLen(busLen), .fifoWr(fifoWr),
    .busAbort(busAbort), .retryOut(retryOut), .errOut(errOut), .winEnd(winEnd)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clearIn();
    startReq = 0; tgtDisc = 0; slvAddrAck = 0; slvRearb = 0;
    slvData = 0; slvBurstTerm = 0; slvErr = 0;
  endtask

  task automatic startTx(input logic [31:0] a, input logic [31:0] b, input logic [31:0] l);
    startAddr = a; winBase = b; winLen = l; startReq = 1;
    tick();
    startReq = 0;
  endtask

  task automatic stopTx();
    clearIn();
    tgtDisc = 1;
    tick();
    clearIn();
    tick();
  endtask

  task automatic ackReq();
    slvAddrAck = 1;
    tick();
    slvAddrAck = 0;
  endtask

  task automatic beats(input int n, input logic [31:0] firstAddr, input string tag);
    for (int i = 0; i < n; i++) begin
      slvData = 1;
      settle();
      chkEq({tag, " fifoWr"}, fifoWr, 1);
      chkEq({tag, " beat addr"}, busAddr, firstAddr + i);
      tick();
    end
    slvData = 0;
  endtask

  task automatic t_reset();
    rstN = 0; clearIn();
    startAddr = 0; winBase = 0; winLen = 0; fifoFree = 0;
    tick(); tick();
    rstN = 1;
    tick();
    settle();
    chkEq("R1 reset busReq", busReq, 0);
    chkEq("R1 reset flags", {fifoWr, busAbort, retryOut, errOut, winEnd}, 0);
  endtask

  task automatic t_basic();
    fifoFree = 20;
    startTx(32'h100, 32'h100, 64);
    settle();
    chkEq("R1 busReq after start", busReq, 1);
    chkEq("R1 busAddr", busAddr, 32'h100);
    chkEq("R2 len capped at 16", busLen, 16);
    ackReq();
    beats(16, 32'h100, "R3");
    settle();
    chkEq("R3 next request", busReq, 1);
    chkEq("R3 next addr", busAddr, 32'h110);
    stopTx();
  endtask

  task automatic t_freeLimit();
    fifoFree = 5;
    startTx(32'h300, 32'h300, 64);
    settle();
    chkEq("R2 len from free", busLen, 5);
    stopTx();
  endtask

  task automatic t_window();
    fifoFree = 30;
    startTx(32'h20E, 32'h200, 20);
    settle();
    chkEq("R2 len from window", busLen, 6);
    ackReq();
    beats(6, 32'h20E, "R4");
    settle();
    chkEq("R4 winEnd", winEnd, 1);
    chkEq("R4 no req at end", busReq, 0);
    chkEq("R4 no error", errOut, 0);
    tick();
    settle();
    chkEq("R4 idle after end", {busReq, winEnd, fifoWr}, 0);
    clearIn();
    tick();
  endtask

  task automatic t_fifoFull();
    fifoFree = 0;
    startTx(32'h400, 32'h400, 64);
    for (int i = 0; i < 3; i++) begin
      settle();
      chkEq("R5 no req while full", busReq, 0);
      tick();
    end
    fifoFree = 3;
    settle();
    chkEq("R5 req when space", busReq, 1);
    chkEq("R5 len", busLen, 3);
    stopTx();
  endtask

  task automatic t_firstRearb();
    fifoFree = 10;
    startTx(32'h500, 32'h500, 64);
    slvRearb = 1;
    settle();
    chkEq("R6 retryOut", retryOut, 1);
    tick();
    slvRearb = 0;
    settle();
    chkEq("R6 idle after retry", {busReq, fifoWr, retryOut}, 0);
    tick();
  endtask

  task automatic t_laterRearb();
    fifoFree = 2;
    startTx(32'h600, 32'h600, 64);
    ackReq();
    beats(2, 32'h600, "R7");
    slvRearb = 1;
    settle();
    chkEq("R7 no retryOut", retryOut, 0);
    chkEq("R7 req addr", busAddr, 32'h602);
    tick();
    slvRearb = 0;
    settle();
    chkEq("R7 re-request", busReq, 1);
    chkEq("R7 same addr", busAddr, 32'h602);
    stopTx();
  endtask

  task automatic t_burstTerm();
    fifoFree = 8;
    startTx(32'h700, 32'h700, 64);
    ackReq();
    beats(2, 32'h700, "R8");
    slvData = 1; slvBurstTerm = 1;
    settle();
    chkEq("R8 last beat written", fifoWr, 1);
    tick();
    clearIn();
    settle();
    chkEq("R8 re-request", busReq, 1);
    chkEq("R8 resume addr", busAddr, 32'h703);
    stopTx();
  endtask

  task automatic t_error();
    fifoFree = 8;
    startTx(32'h800, 32'h800, 64);
    ackReq();
    beats(1, 32'h800, "R9");
    slvData = 1; slvErr = 1;
    settle();
    chkEq("R9 errOut in burst", errOut, 1);
    chkEq("R9 beat dropped", fifoWr, 0);
    tick();
    clearIn();
    settle();
    chkEq("R9 idle after error", {busReq, fifoWr}, 0);
    tick();
    startTx(32'h900, 32'h900, 64);
    slvErr = 1;
    settle();
    chkEq("R9 errOut on request", errOut, 1);
    tick();
    clearIn();
    settle();
    chkEq("R9 no req after error", busReq, 0);
    tick();
  endtask

  task automatic t_disconnect();
    fifoFree = 8;
    startTx(32'hA00, 32'hA00, 64);
    ackReq();
    beats(1, 32'hA00, "R10");
    slvData = 1; tgtDisc = 1;
    settle();
    chkEq("R10 beat ignored", fifoWr, 0);
    chkEq("R10 busAbort", busAbort, 1);
    tick();
    clearIn();
    settle();
    chkEq("R10 stopped", {busReq, fifoWr, busAbort}, 0);
    tick();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_freeLimit();
    t_window();
    t_fifoFull();
    t_firstRearb();
    t_laterRearb();
    t_burstTerm();
    t_error();
    t_disconnect();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule